// File: doc/BRIEF.md
# Dual-Tap Timer Clock Prescaler

This block is the shared time base for two timer counters: a capture/compare counter and a PWM counter. A nine-bit binary divider runs from the system clock. Two independent selectors each pick one divider tap or a synchronised external clock pin. Each selector drives a count-enable output that is high for one system clock cycle at a time. The counters advance on those enables; the counters themselves are outside this block.

Software uses a small 16-bit word port to set both selections and to read the raw divider value. While the freeze input is high, software can also write the divider. The freeze input also stops the divider and gates both enables low. The capture/compare selection accepts only one write after reset, unless test mode or freeze mode is active. The PWM selection can be changed at any time.

The block has no streaming data path. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset, the divider reads 0, the capture/compare select reads 1, the PWM select reads 0, address 3 reads 0, and both enable outputs are low.
- R2: With select code k (0 to 6), the channel's enable is high for exactly one cycle every 2^(k+1) system clock cycles.
- R3: An enable pulse appears in the cycle after a clock edge at which the divider's low k+1 bits are all ones and the divider is running. After divider value 0x0F5 is loaded in freeze with code 2, the first pulse follows the 3rd edge after release and the next pulse follows the 11th edge.
- R4: Select code 7 chooses the external clock input. Each rising edge on that input gives exactly one enable pulse, after a two-flop synchronizer and an edge detector.
- R5: The PWM select field (address 2, bits [2:0]) takes every write, and reads return the last value written.
- R6: The capture/compare select field (address 1, bits [2:0]) takes the first write after reset. Later writes are ignored while both test and freeze are low, and are taken while either is high.
- R7: A read strobe on address 0 returns the divider value of that cycle in bits [8:0] on the next cycle, with bits [15:9] zero. Two reads one cycle apart differ by 1 modulo 512.
- R8: A write to address 0 loads bits [8:0] into the divider only while freeze is high. Otherwise the divider keeps counting as if there had been no write.
- R9: While freeze is high, the divider holds its value and both enables stay low, including enables from external clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Freeze mode: stops the divider, gates the enables, allows divider writes |
| test_i | input | 1 | Test mode: lifts the write-once lock on the capture/compare select |
| ext_clk_i | input | 1 | External clock, asynchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 divider, 1 capture/compare select, 2 PWM select, 3 reserved |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| cc_tick_o | output | 1 | Capture/compare counter enable pulse |
| pwm_tick_o | output | 1 | PWM counter enable pulse |

## Verification
The hardest case to reach from the ports is the exact phase of a pulse relative to the divider state. The divider runs freely from reset, so its value at any moment is normally unknown. The bench uses freeze to load a known divider value and choose a tap, then releases freeze on a known edge and counts edges to the first and second pulses. A second reset with freeze low sets up a clean first write to the capture/compare selector. This is needed to show that the lock blocks the next write and that test and freeze each lift the lock.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DIV     = 2'd0,
    ADR_CC_SEL  = 2'd1,
    ADR_PWM_SEL = 2'd2,
    ADR_RSVD    = 2'd3
  } psc_addr_e;
endpackage

// File: rtl/psc_divider.sv
// Free-running binary divider with freeze-time load and per-tap carry flags.
module psc_divider #(
  parameter int STAGES = 9,
  parameter int TAPS   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STAGES-1:0] cnt_o,
  output logic [TAPS-1:0]   carry_o
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= cnt_q + STAGES'(1);
  end

  // A tap completes a period when the increment carries into the stage above it.
  for (genvar k = 0; k < TAPS; k++) begin : g_carry
    assign carry_o[k] = run_i & (&cnt_q[k:0]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psc_ext_sync.sv
// Brings the external clock into the system domain and flags rising edges.
module psc_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/psc_tap_mux.sv
// One channel: picks a divider carry or the external edge, registers the pulse.
module psc_tap_mux #(
  parameter int TAPS  = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TAPS-1:0]  carry_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);
  localparam int SRC_N = 2 ** SEL_W;

  logic [SRC_N-1:0] src;
  logic             tick_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (i < TAPS) begin : g_tap
      assign src[i] = carry_i[i];
    end else begin : g_ext
      assign src[i] = ext_rise_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= enable_i & src[sel_i];
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/psc_regs.sv
// Select registers with write-once lock, and the registered read port.
module psc_regs
  import psc_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int STAGES  = 9,
  parameter int CC_RST  = 1,
  parameter int PWM_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              test_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [STAGES-1:0] div_val_i,
  output logic [SEL_W-1:0]  cc_sel_o,
  output logic [SEL_W-1:0]  pwm_sel_o,
  output logic              cc_locked_o,
  output logic [DATA_W-1:0] rdata_o
);
  psc_addr_e         addr;
  logic [SEL_W-1:0]  cc_sel_q, pwm_sel_q;
  logic              locked_q;
  logic              cc_open;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign addr    = psc_addr_e'(addr_i);
  assign cc_open = ~locked_q | freeze_i | test_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_sel_q  <= SEL_W'(CC_RST);
      pwm_sel_q <= SEL_W'(PWM_RST);
      locked_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr == ADR_CC_SEL && cc_open) begin
        cc_sel_q <= wsel_i;
        locked_q <= 1'b1;
      end
      if (addr == ADR_PWM_SEL) pwm_sel_q <= wsel_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      ADR_DIV:     rd_mux[STAGES-1:0] = div_val_i;
      ADR_CC_SEL:  rd_mux[SEL_W-1:0]  = cc_sel_q;
      ADR_PWM_SEL: rd_mux[SEL_W-1:0]  = pwm_sel_q;
      default:     rd_mux = '0;
    endcase
  end

  // Whole word captured in one edge so the divider bits are coherent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign cc_sel_o    = cc_sel_q;
  assign pwm_sel_o   = pwm_sel_q;
  assign cc_locked_o = locked_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import psc_pkg::*;
#(
  parameter int DIV_STAGES  = 9,
  parameter int TAP_COUNT   = 7,
  parameter int SYNC_STAGES = 2,
  parameter int CC_RST_SEL  = 1,
  parameter int PWM_RST_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              test_i,
  input  logic              ext_clk_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cc_tick_o,
  output logic              pwm_tick_o
);
  localparam int SEL_W = $clog2(TAP_COUNT + 1);
  localparam int CH_N  = 2;

  logic                  run;
  logic                  div_load;
  logic [DIV_STAGES-1:0] div_value;
  logic [TAP_COUNT-1:0]  carry;
  logic                  ext_rise;
  logic [SEL_W-1:0]      cc_sel, pwm_sel;
  logic                  cc_locked;
  logic [CH_N-1:0][SEL_W-1:0] ch_sel;
  logic [CH_N-1:0]       ch_tick;
  logic                  unused_wdata_hi;

  assign run             = ~freeze_i;
  assign div_load        = freeze_i & reg_wr_i & (psc_addr_e'(reg_addr_i) == ADR_DIV);
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:DIV_STAGES];

  psc_divider #(.STAGES(DIV_STAGES), .TAPS(TAP_COUNT)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .load_i     (div_load),
    .load_val_i (reg_wdata_i[DIV_STAGES-1:0]),
    .cnt_o      (div_value),
    .carry_o    (carry)
  );

  psc_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  psc_regs #(
    .SEL_W(SEL_W), .STAGES(DIV_STAGES),
    .CC_RST(CC_RST_SEL), .PWM_RST(PWM_RST_SEL)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze_i    (freeze_i),
    .test_i      (test_i),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wsel_i      (reg_wdata_i[SEL_W-1:0]),
    .div_val_i   (div_value),
    .cc_sel_o    (cc_sel),
    .pwm_sel_o   (pwm_sel),
    .cc_locked_o (cc_locked),
    .rdata_o     (reg_rdata_o)
  );

  assign ch_sel[0] = cc_sel;
  assign ch_sel[1] = pwm_sel;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    psc_tap_mux #(.TAPS(TAP_COUNT), .SEL_W(SEL_W)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (run),
      .sel_i      (ch_sel[c]),
      .carry_i    (carry),
      .ext_rise_i (ext_rise),
      .tick_o     (ch_tick[c])
    );
  end

  assign cc_tick_o  = ch_tick[0];
  assign pwm_tick_o = ch_tick[1];
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int STAGES = 9,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze_i,
  input logic              test_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_addr_i,
  input logic [15:0]       reg_wdata_i,
  input logic [15:0]       reg_rdata_o,
  input logic              cc_tick_o,
  input logic              pwm_tick_o,
  input logic [STAGES-1:0] div_value,
  input logic [SEL_W-1:0]  cc_sel,
  input logic [SEL_W-1:0]  pwm_sel,
  input logic              cc_locked
);
  p_freeze_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> (!cc_tick_o && !pwm_tick_o));

  p_freeze_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !(reg_wr_i && reg_addr_i == 2'd0)) |=> $stable(div_value));

  p_divider_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_i |=> (div_value == $past(div_value) + STAGES'(1)));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_tick_o && cc_sel != '1 && !reg_wr_i) |=> !cc_tick_o);

  p_cc_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd1 && cc_locked && !freeze_i && !test_i)
      |=> $stable(cc_sel));

  p_pwm_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd2) |=> (pwm_sel == $past(reg_wdata_i[SEL_W-1:0])));

  p_read_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == 2'd0) |=> (reg_rdata_o[15:STAGES] == '0));
endmodule

bind tmr_prescaler psc_checker #(.STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .freeze_i    (freeze_i),
  .test_i      (test_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cc_tick_o   (cc_tick_o),
  .pwm_tick_o  (pwm_tick_o),
  .div_value   (div_value),
  .cc_sel      (cc_sel),
  .pwm_sel     (pwm_sel),
  .cc_locked   (cc_locked)
);

// File: tb/tb_tmr_prescaler.sv
module tb_tmr_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 9;
  // channel (0 cc, 1 pwm), select code, expected period
  localparam int VEC_CH [VEC_N] = '{1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int VEC_SEL[VEC_N] = '{0, 1, 2, 3, 4, 5, 6, 0, 6};
  localparam int VEC_PER[VEC_N] = '{2, 4, 8, 16, 32, 64, 128, 2, 128};

  logic clk = 0, rst_n = 0, freeze = 1, test = 0, ext = 0;
  logic wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic cc_tick, pwm_tick;
  int checks = 0, failures = 0;
  bit done = 0;

  tmr_prescaler dut (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .test_i(test), .ext_clk_i(ext),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cc_tick_o(cc_tick), .pwm_tick_o(pwm_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Register tasks are entered at a negedge and return at the next negedge.
  task automatic wr_reg(input int a, input int d);
    wr = 1; addr = 2'(a); wdata = 16'(d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input int a, output int d);
    rd = 1; addr = 2'(a);
    @(negedge clk);
    rd = 0;
    d = int'(rdata);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic tick_of(input int ch);
    return (ch == 0) ? cc_tick : pwm_tick;
  endfunction

  task automatic measure(input int ch, output int per, output int wid);
    int n = 0;
    logic v = 0;
    while (!v && n < 2000) begin @(negedge clk); v = tick_of(ch); n++; end
    wid = 0;
    while (v && wid < 300) begin wid++; @(negedge clk); v = tick_of(ch); end
    per = wid;
    while (!v && per < 2000) begin @(negedge clk); v = tick_of(ch); per++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d, d2, per, wid, first, second, pulses;
    do_reset();
    @(negedge clk);

    // R1 reset state (freeze held so divider is still 0)
    rd_reg(0, d);  chk("R1", "divider after reset", d, 0);
    rd_reg(1, d);  chk("R1", "cc select after reset", d, 1);
    rd_reg(2, d);  chk("R1", "pwm select after reset", d, 0);
    rd_reg(3, d);  chk("R1", "reserved read", d, 0);
    chk("R1", "ticks after reset", int'(cc_tick) + int'(pwm_tick), 0);

    // R9 freeze holds the divider and gates the enables
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); pulses += int'(cc_tick) + int'(pwm_tick);
    end
    chk("R9", "pulses in freeze", pulses, 0);
    rd_reg(0, d);  chk("R9", "divider held in freeze", d, 0);

    // R8 and R7: freeze-time load, upper bits read zero
    wr_reg(0, 16'hFFFF);
    rd_reg(0, d);  chk("R7", "divider read with upper zero", d, 16'h01FF);
    wr_reg(0, 16'h01F5);
    rd_reg(0, d);  chk("R8", "divider load in freeze", d, 16'h01F5);

    // R3 pulse phase after a known load
    wr_reg(2, 2);
    wr_reg(0, 16'h00F5);
    freeze = 0;
    first = -1; second = -1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (pwm_tick) begin
        if (first < 0) first = i; else if (second < 0) second = i;
      end
    end
    chk("R3", "first pulse edge", first, 3);
    chk("R3", "second pulse edge", second, 11);

    // R7 running reads, R8 ignored write outside freeze
    rd_reg(0, d); rd_reg(0, d2);
    chk("R7", "back-to-back read step", (d2 - d + 512) % 512, 1);
    rd_reg(0, d); wr_reg(0, 0); rd_reg(0, d2);
    chk("R8", "write outside freeze ignored", (d2 - d + 512) % 512, 2);

    // R6 write-once lock, from a fresh reset with freeze low
    do_reset();
    @(negedge clk);
    wr_reg(1, 3); rd_reg(1, d); chk("R6", "first cc write", d, 3);
    wr_reg(1, 5); rd_reg(1, d); chk("R6", "locked cc write ignored", d, 3);
    test = 1; wr_reg(1, 5); test = 0;
    rd_reg(1, d); chk("R6", "cc write in test mode", d, 5);
    freeze = 1; wr_reg(1, 4); freeze = 0;
    rd_reg(1, d); chk("R6", "cc write in freeze", d, 4);

    // R2 and R5 table of tap periods
    for (int v = 0; v < VEC_N; v++) begin
      if (VEC_CH[v] == 0) begin test = 1; wr_reg(1, VEC_SEL[v]); test = 0; end
      else begin
        wr_reg(2, VEC_SEL[v]);
        rd_reg(2, d); chk("R5", "pwm select readback", d, VEC_SEL[v]);
      end
      measure(VEC_CH[v], per, wid);
      chk("R2", $sformatf("period ch%0d code%0d", VEC_CH[v], VEC_SEL[v]), per, VEC_PER[v]);
      chk("R2", $sformatf("width ch%0d code%0d", VEC_CH[v], VEC_SEL[v]), wid, 1);
    end

    // R4 external clock on the PWM channel
    wr_reg(2, 7);
    repeat (4) @(negedge clk);
    pulses = 0;
    for (int e = 0; e < 5; e++) begin
      ext = 1; for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(pwm_tick); end
      ext = 0; for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(pwm_tick); end
    end
    for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(pwm_tick); end
    chk("R4", "pulses per external edge", pulses, 5);

    // R9 external edges gated in freeze
    freeze = 1;
    pulses = 0;
    for (int e = 0; e < 2; e++) begin
      ext = 1; for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(pwm_tick); end
      ext = 0; for (int i = 0; i < 6; i++) begin @(negedge clk); pulses += int'(pwm_tick); end
    end
    chk("R9", "external pulses in freeze", pulses, 0);
    freeze = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule